// File: doc/BRIEF.md
# Bang-Bang Fine-Frequency Integrator with Sub-Step Dither

This block turns a stream of one-bit early/late decisions from a bang-bang phase detector into the fine-frequency control of an oscillator. Every qualified decision moves an integrating register by exactly one count, up or down. The register never wraps. It holds at its lower or upper end, and a flag reports any decision that tries to push it past that end. The upper nibble of the register drives four binary-weighted load capacitors directly.

The lower nibble is the fraction below one capacitor step. A first-order delta-sigma modulator, clocked by an oscillator-cycle tick, turns that fraction into one extra load bit. This bit has the weight of the capacitor LSB. It is asserted on as many ticks in every sixteen as the fraction value, so the average load can be set in steps sixteen times finer than the capacitor bank allows.

The full register value is also exported so that a slower coarse loop can steer its own control back toward a center. The register loads a programmable center value during reset.

Top module: `bbf_fine_freq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the integrator loads `center_code`, the dither phase is cleared and `dither` goes low. The flags are low after reset when no decision is presented.
- R2: On a clock edge where `dec_vld` is 1 and the integrator is not at the relevant limit, the integrator changes by exactly one count. It goes up (more load, lower frequency) when `dec_ahead` is 1, meaning the oscillator is ahead. It goes down when `dec_ahead` is 0, meaning the oscillator is behind.
- R3: A clock edge with `dec_vld` low leaves the integrator unchanged, whatever `dec_ahead` is.
- R4: `acc_word` shows the whole 8-bit integrator. `cap_code` equals its bits 7:4.
- R5: The integrator saturates. An up-step at 255 leaves it at 255, and a down-step at 0 leaves it at 0.
- R6: `sat_hi` is 1 exactly when the integrator is 255 and a valid up decision is presented in the same cycle. `sat_lo` is 1 exactly when the integrator is 0 and a valid down decision is presented.
- R7: Let k be integrator bits 3:0, held constant. Then over any 16 consecutive edges with `osc_tick` high, `dither` reads 1 after exactly k of them.
- R8: `dither` changes only on clock edges where `osc_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| center_code | input | 8 | Integrator value loaded during reset |
| dec_vld | input | 1 | Qualifies a bang-bang decision this cycle |
| dec_ahead | input | 1 | 1: oscillator ahead (step up), 0: behind (step down) |
| osc_tick | input | 1 | One-cycle enable per oscillator cycle for the dither |
| cap_code | output | 4 | Binary-weighted capacitor control, integrator bits 7:4 |
| dither | output | 1 | Extra capacitor-LSB load bit from the modulator |
| sat_hi | output | 1 | Valid up decision blocked at the top limit |
| sat_lo | output | 1 | Valid down decision blocked at the bottom limit |
| acc_word | output | 8 | Full integrator value for the coarse loop |

## Verification
The hardest property to reach is the dither density, because it only shows after many ticks with the fraction held still. The bench does not drive the fraction through long chains of decisions. It sets the fraction through `center_code` at reset. It then counts the ones over sixteen ticks for several fraction values, both with back-to-back ticks and with ticks spaced apart. The saturation flags need the integrator pinned at 0 or 255. The bench gets there by loading a center near the limit and then issuing a short burst of decisions past it.

// File: rtl/bbf_pkg.sv
// Package bbf_pkg
// Shared sizes for the fine-frequency integrator and its dither path.
// Assumes the integrator splits into a capacitor field above a fraction field.
package bbf_pkg;
    localparam int ACC_W  = 8;
    localparam int FRAC_W = 4;
    localparam int CAP_W  = ACC_W - FRAC_W;

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [CAP_W-1:0]  cap_t;
endpackage

// File: rtl/bbf_accum.sv
// Module bbf_accum
// Saturating up/down integrator of bang-bang decisions.
// Each qualified decision moves the value by one count. Limits are 0 and all-ones.
// Assumes decisions arrive already synchronous to clk.
module bbf_accum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] center,
    input  logic         vld,
    input  logic         ahead,
    output logic [W-1:0] value,
    output logic         at_top,
    output logic         at_bottom
);
    localparam logic [W-1:0] TOP    = {W{1'b1}};
    localparam logic [W-1:0] BOTTOM = '0;

    logic [W-1:0] acc_q;

    // Limit detection for saturation and flags
    always_comb begin
        at_top    = (acc_q == TOP);
        at_bottom = (acc_q == BOTTOM);
    end

    // Integrate one step per valid decision, holding at either limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= center;
        end else if (vld) begin
            if (ahead && !at_top)
                acc_q <= acc_q + 1'b1;
            else if (!ahead && !at_bottom)
                acc_q <= acc_q - 1'b1;
        end
    end

    assign value = acc_q;

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && ahead && acc_q != TOP) |=> acc_q == $past(acc_q) + 1'b1); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !ahead && acc_q != BOTTOM) |=> acc_q == $past(acc_q) - 1'b1); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(acc_q)); // R3
    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && ahead && acc_q == TOP) |=> acc_q == TOP); // R5
    AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !ahead && acc_q == BOTTOM) |=> acc_q == BOTTOM); // R5
endmodule

// File: rtl/bbf_dither.sv
// Module bbf_dither
// First-order delta-sigma modulator. On each tick it adds the fraction to a
// phase register, and the carry becomes the output bit.
// With a constant fraction k, any 16 consecutive ticks give exactly k ones.
// Assumes tick is a one-cycle enable in the clk domain.
module bbf_dither #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [FW-1:0] frac,
    output logic          bit_out
);
    logic [FW-1:0] phase_q;
    logic [FW:0]   sum;
    logic          bit_q;

    // Phase plus fraction, with carry in the top bit
    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, frac};
    end

    // Advance the phase and register the carry on every tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            bit_q   <= 1'b0;
        end else if (tick) begin
            phase_q <= sum[FW-1:0];
            bit_q   <= sum[FW];
        end
    end

    assign bit_out = bit_q;

    AST_DITHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(bit_q)); // R8
    AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frac == '0) |=> !bit_q); // R7
    AST_FULL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frac == {FW{1'b1}} && phase_q != '0) |=> bit_q); // R7
endmodule

// File: rtl/bbf_fine_freq.sv
// Module bbf_fine_freq (top)
// Integrates bang-bang decisions into a saturating word. The upper field drives
// a binary-weighted capacitor bank. The lower field is dithered into one extra
// capacitor-LSB bit on oscillator ticks. Reports blocked pushes at either limit.
// Assumes all inputs are synchronous to clk.
module bbf_fine_freq
    import bbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] center_code,
    input  logic             dec_vld,
    input  logic             dec_ahead,
    input  logic             osc_tick,
    output logic [CAP_W-1:0] cap_code,
    output logic             dither,
    output logic             sat_hi,
    output logic             sat_lo,
    output logic [ACC_W-1:0] acc_word
);
    acc_t acc;
    logic top_hit;
    logic bottom_hit;

    bbf_accum #(.W(ACC_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .center    (center_code),
        .vld       (dec_vld),
        .ahead     (dec_ahead),
        .value     (acc),
        .at_top    (top_hit),
        .at_bottom (bottom_hit)
    );

    bbf_dither #(.FW(FRAC_W)) u_dither (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (osc_tick),
        .frac    (acc[FRAC_W-1:0]),
        .bit_out (dither)
    );

    // Capacitor controls: one line per binary-weighted bank element
    for (genvar b = 0; b < CAP_W; b++) begin : g_cap
        assign cap_code[b] = acc[FRAC_W + b];
    end

    // Flag a decision that would push past a limit
    always_comb begin
        sat_hi = top_hit && dec_vld && dec_ahead;
        sat_lo = bottom_hit && dec_vld && !dec_ahead;
    end

    assign acc_word = acc;

    AST_SAT_HI_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        sat_hi |=> acc_word == {ACC_W{1'b1}}); // R6
    AST_SAT_LO_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        sat_lo |=> acc_word == '0); // R6
    AST_CAP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_code == acc_word[ACC_W-1:FRAC_W]); // R4
endmodule

// File: tb/bbf_fine_freq_test.sv
module bbf_fine_freq_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] center_code;
    logic       dec_vld;
    logic       dec_ahead;
    logic       osc_tick;
    logic [3:0] cap_code;
    logic       dither;
    logic       sat_hi;
    logic       sat_lo;
    logic [7:0] acc_word;

    int n_chk = 0;
    int n_bad = 0;

    bbf_fine_freq uut (
        .clk(clk), .rst_n(rst_n), .center_code(center_code),
        .dec_vld(dec_vld), .dec_ahead(dec_ahead), .osc_tick(osc_tick),
        .cap_code(cap_code), .dither(dither), .sat_hi(sat_hi),
        .sat_lo(sat_lo), .acc_word(acc_word)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Hold reset for two edges with the given center. Inputs change on the falling edge.
    task automatic do_reset(input logic [7:0] c);
        @(negedge clk);
        rst_n = 1'b0; center_code = c; dec_vld = 1'b0; dec_ahead = 1'b0; osc_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one decision for one edge, then check after it
    task automatic step(input logic ahead);
        dec_vld = 1'b1; dec_ahead = ahead;
        @(negedge clk);
        dec_vld = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(8'h5A);
        chk("R1 acc", acc_word, 8'h5A);
        chk("R1 dither", dither, 0);
        chk("R1 sat_hi", sat_hi, 0);
        chk("R1 sat_lo", sat_lo, 0);
        chk("R4 cap", cap_code, 5);
    endtask

    task automatic t_steps();
        do_reset(8'h4F);
        step(1'b1);
        chk("R2 up", acc_word, 8'h50);
        chk("R4 cap after carry", cap_code, 5);
        step(1'b0);
        step(1'b0);
        chk("R2 down", acc_word, 8'h4E);
        chk("R4 cap", cap_code, 4);
    endtask

    task automatic t_idle();
        do_reset(8'h33);
        dec_vld = 1'b0;
        dec_ahead = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 ignored ahead", acc_word, 8'h33);
        dec_ahead = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 ignored behind", acc_word, 8'h33);
    endtask

    task automatic t_sat_hi();
        do_reset(8'hFD);
        for (int i = 0; i < 2; i++) step(1'b1);
        chk("R5 reach top", acc_word, 255);
        dec_vld = 1'b1; dec_ahead = 1'b1;
        #1;
        chk("R6 sat_hi set", sat_hi, 1);
        chk("R6 sat_lo clear", sat_lo, 0);
        repeat (3) @(negedge clk);
        dec_vld = 1'b0;
        #1;
        chk("R5 held top", acc_word, 255);
        chk("R6 sat_hi drops without decision", sat_hi, 0);
        dec_vld = 1'b1; dec_ahead = 1'b0;
        #1;
        chk("R6 no sat_hi on down", sat_hi, 0);
        @(negedge clk);
        dec_vld = 1'b0;
        chk("R2 leave top", acc_word, 254);
    endtask

    task automatic t_sat_lo();
        do_reset(8'h01);
        step(1'b0);
        chk("R5 reach bottom", acc_word, 0);
        dec_vld = 1'b1; dec_ahead = 1'b0;
        #1;
        chk("R6 sat_lo set", sat_lo, 1);
        chk("R6 sat_hi clear", sat_hi, 0);
        repeat (4) @(negedge clk);
        dec_vld = 1'b0;
        #1;
        chk("R5 held bottom", acc_word, 0);
        chk("R6 sat_lo drops", sat_lo, 0);
    endtask

    // Count dither ones over 16 ticks for fraction k, with gap idle cycles between ticks
    task automatic t_dither(input int k, input int gap);
        int ones = 0;
        logic held;
        do_reset({4'h8, k[3:0]});
        for (int t = 0; t < 16; t++) begin
            osc_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0;
            ones += int'(dither);
            held = dither;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk("R8 hold between ticks", dither, held);
            end
        end
        chk($sformatf("R7 density k=%0d gap=%0d", k, gap), ones, k);
        chk("R3 acc untouched by ticks", acc_word, {4'h8, k[3:0]});
    endtask

    initial begin
        rst_n = 1'b0; center_code = '0; dec_vld = 1'b0; dec_ahead = 1'b0; osc_tick = 1'b0;
        t_reset();
        t_steps();
        t_idle();
        t_sat_hi();
        t_sat_lo();
        t_dither(0, 0);
        t_dither(1, 0);
        t_dither(7, 0);
        t_dither(15, 0);
        t_dither(5, 2);
        t_dither(12, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule